// File: doc/BRIEF.md
# Randomized Internal Clock Enable Generator

This block turns every edge of the external clock into one of two kinds of cycle: an internal cycle, on which the processor core is allowed to advance, or a rest cycle. The choice is made by an on-chip pseudo-random bit source, so the core runs on an unpredictable subset of external cycles. About one cycle in four is internal. On every rest cycle a dummy-load enable is raised instead, so that supply current stays similar whether or not the core works. A third enable is high on every cycle after reset and drives the parts that must follow the external clock exactly: the timer and the serial I/O shift register.

The random source is a 32-bit Galois LFSR. A seed can be loaded through a small valid/ready port. The port never applies back-pressure once reset is over: `seed_ready` is high on every cycle out of reset, and a seed is taken on any edge where `seed_valid` and `seed_ready` are both high. A window counter reports how many internal cycles occurred in the most recently completed window of 1000 external cycles, so the long-run ratio can be measured.

Top module: `rand_clk_en_gen`

## Requirements
- R1: While `rst_n` is low, `core_en`, `dummy_en`, `io_en`, `seed_ready` and `win_valid` are 0, `win_count` is 0, and the generator state is the default seed 32'hACE1_2468.
- R2: From the first clock edge after reset release, `io_en` is 1 on every cycle.
- R3: From the first clock edge after reset release, exactly one of `core_en` and `dummy_en` is 1 on every cycle.
- R4: After each edge out of reset, `core_en` is 1 exactly when bit 0 and bit 16 of the generator state held before that edge are both 1. Otherwise `dummy_en` is 1.
- R5: On each edge out of reset with no seed taken, the state S advances as a right-shifting Galois LFSR: next = (S >> 1) XOR (S[0] ? 32'h8020_0003 : 0).
- R6: On an edge where `seed_valid` and `seed_ready` are both 1 and `seed_data` is nonzero, the state becomes `seed_data`. The enables set on that same edge still come from the old state.
- R7: A taken seed of zero loads the default seed 32'hACE1_2468 instead, so the state is never zero.
- R8: `seed_ready` is 1 on every cycle after the first edge out of reset. The seed port never stalls.
- R9: On the edge that ends every 1000th external cycle after reset, `win_count` takes the number of internal cycles in those 1000 cycles and `win_valid` becomes 1 and stays 1.
- R10: With the default seed and occasional seed loads, every completed window reports between 200 and 300 internal cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_valid | input | 1 | Seed offered on `seed_data` |
| seed_data | input | 32 | Seed value; zero is replaced by the default seed |
| seed_ready | output | 1 | Seed port accepts a seed (high whenever out of reset) |
| core_en | output | 1 | Internal-cycle enable for the processor core |
| dummy_en | output | 1 | Dummy-load enable on rest cycles |
| io_en | output | 1 | Free-running enable for the timer and I/O shift register |
| win_count | output | 10 | Internal cycles in the last completed 1000-cycle window |
| win_valid | output | 1 | At least one window has completed |

## Verification
The assertions assume that `rst_n` is held low across at least one rising clock edge before it is released. They also assume that `seed_valid` and `seed_data` settle away from the rising edge, so each edge sees only one seed offer. The stimulus asserts reset before the first edge and changes all inputs on falling edges. Seed loads are rare and random, with one directed zero seed among them, so that most windows run the generator freely. The bench reference model tracks the generator state across every load and predicts the enables and window counts edge by edge.

// File: rtl/rce_pkg.sv
package rce_pkg;
  localparam int unsigned LFSR_BITS = 32;
  localparam logic [LFSR_BITS-1:0] POLY_MASK = 32'h8020_0003;
  localparam logic [LFSR_BITS-1:0] SEED_DFLT = 32'hACE1_2468;

  typedef enum logic [1:0] {
    SLOT_IDLE = 2'b00,
    SLOT_CORE = 2'b01,
    SLOT_REST = 2'b10
  } slot_e;

  function automatic logic [LFSR_BITS-1:0] galois_next(
    input logic [LFSR_BITS-1:0] s,
    input logic [LFSR_BITS-1:0] mask
  );
    galois_next = (s >> 1) ^ (s[0] ? mask : '0);
  endfunction
endpackage

// File: rtl/rce_lfsr.sv
module rce_lfsr #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] MASK = 32'h8020_0003,
  parameter logic [W-1:0] SEED0 = 32'hACE1_2468
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] state
);
  logic [W-1:0] stepped;
  logic [W-1:0] seed_fix;

  always_comb begin
    stepped  = (state >> 1) ^ (state[0] ? MASK : '0);
    seed_fix = (load_val == '0) ? SEED0 : load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= SEED0;
    else if (load) state <= seed_fix;
    else           state <= stepped;
  end

  // R7: state is never zero
  a_r7_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);
  // R6: a nonzero seed taken on an edge is the next state
  a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val != '0) |=> state == $past(load_val));
  // R7: a zero seed yields the default
  a_r7_zero_seed: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val == '0) |=> state == SEED0);
endmodule

// File: rtl/rce_slot_sel.sv
module rce_slot_sel
  import rce_pkg::*;
#(
  parameter int unsigned W = 32,
  parameter int unsigned TAP_A = 0,
  parameter int unsigned TAP_B = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] state,
  output logic         pick,
  output logic         core_en,
  output logic         dummy_en,
  output logic         io_en
);
  slot_e slot_q;

  always_comb pick = state[TAP_A] & state[TAP_B];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    slot_q <= SLOT_IDLE;
    else if (pick) slot_q <= SLOT_CORE;
    else           slot_q <= SLOT_REST;
  end

  always_comb begin
    core_en  = (slot_q == SLOT_CORE);
    dummy_en = (slot_q == SLOT_REST);
    io_en    = (slot_q != SLOT_IDLE);
  end

  // R3: exactly one of the two enables once running
  a_r3_one_of_two: assert property (@(posedge clk) disable iff (!rst_n)
    io_en |-> (core_en ^ dummy_en));
  // R2: free-running enable never drops once up
  a_r2_io_hold: assert property (@(posedge clk) disable iff (!rst_n)
    io_en |=> io_en);
  // R4: core enable follows the two state taps of the previous cycle
  a_r4_taps: assert property (@(posedge clk) disable iff (!rst_n)
    io_en |-> core_en == ($past(state[TAP_A]) & $past(state[TAP_B])));

  // R1: both enables low while in reset
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_idle: assert (!core_en && !dummy_en && !io_en);
    end
  end
endmodule

// File: rtl/rce_window.sv
module rce_window #(
  parameter int unsigned WINDOW = 1000,
  localparam int unsigned CW = $clog2(WINDOW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  output logic [CW-1:0] count,
  output logic          valid
);
  logic [CW-1:0] pos;
  logic [CW-1:0] acc;
  logic          last;

  always_comb last = (pos == CW'(WINDOW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos   <= '0;
      acc   <= '0;
      count <= '0;
      valid <= 1'b0;
    end else if (last) begin
      pos   <= '0;
      acc   <= '0;
      count <= acc + CW'(tick);
      valid <= 1'b1;
    end else begin
      pos <= pos + 1'b1;
      acc <= acc + CW'(tick);
    end
  end

  // R9: running sum never exceeds cycles seen so far in the window
  a_r9_acc_bound: assert property (@(posedge clk) disable iff (!rst_n)
    acc <= pos);
  // R9: once a window completes the flag stays set
  a_r9_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> valid);
  // R9: flag rises only at the window boundary
  a_r9_rise_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> pos == '0);
endmodule

// File: rtl/rand_clk_en_gen.sv
module rand_clk_en_gen
  import rce_pkg::*;
#(
  parameter int unsigned LFSR_W = LFSR_BITS,
  parameter logic [LFSR_W-1:0] MASK = POLY_MASK,
  parameter logic [LFSR_W-1:0] SEED0 = SEED_DFLT,
  parameter int unsigned TAP_A = 0,
  parameter int unsigned TAP_B = 16,
  parameter int unsigned WINDOW = 1000,
  localparam int unsigned CW = $clog2(WINDOW + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed_valid,
  input  logic [LFSR_W-1:0] seed_data,
  output logic              seed_ready,
  output logic              core_en,
  output logic              dummy_en,
  output logic              io_en,
  output logic [CW-1:0]     win_count,
  output logic              win_valid
);
  logic [LFSR_W-1:0] state;
  logic              pick;
  logic              take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seed_ready <= 1'b0;
    else        seed_ready <= 1'b1;
  end

  always_comb take = seed_valid & seed_ready;

  rce_lfsr #(.W(LFSR_W), .MASK(MASK), .SEED0(SEED0)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .load(take), .load_val(seed_data), .state(state)
  );

  rce_slot_sel #(.W(LFSR_W), .TAP_A(TAP_A), .TAP_B(TAP_B)) u_sel (
    .clk(clk), .rst_n(rst_n), .state(state), .pick(pick),
    .core_en(core_en), .dummy_en(dummy_en), .io_en(io_en)
  );

  rce_window #(.WINDOW(WINDOW)) u_win (
    .clk(clk), .rst_n(rst_n), .tick(pick), .count(win_count), .valid(win_valid)
  );

  // R8: port stays ready once out of reset
  a_r8_ready_hold: assert property (@(posedge clk) disable iff (!rst_n)
    seed_ready |=> seed_ready);
  // R8: ready and free-running enable come up together
  a_r8_ready_io: assert property (@(posedge clk) disable iff (!rst_n)
    seed_ready == io_en);
endmodule

// File: tb/sim_rand_clk_en_gen.sv
`timescale 1ns/1ps
module sim_rand_clk_en_gen;
  localparam logic [31:0] MASK  = 32'h8020_0003;
  localparam logic [31:0] SEED0 = 32'hACE1_2468;
  localparam int WINDOW = 1000;
  localparam int CYCLES = 30000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seed_valid = 1'b0;
  logic [31:0] seed_data = '0;
  logic        seed_ready, core_en, dummy_en, io_en, win_valid;
  logic [9:0]  win_count;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rand_clk_en_gen u0 (
    .clk(clk), .rst_n(rst_n), .seed_valid(seed_valid), .seed_data(seed_data),
    .seed_ready(seed_ready), .core_en(core_en), .dummy_en(dummy_en),
    .io_en(io_en), .win_count(win_count), .win_valid(win_valid)
  );

  function automatic logic [31:0] ref_step(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? MASK : 32'h0);
  endfunction

  function automatic logic [31:0] ref_seed(input logic [31:0] d);
    return (d == 32'h0) ? SEED0 : d;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] ms;
    int wcyc, acc, exp_win, loads;
    bit exp_valid, sv, zero_done, ec;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!core_en && !dummy_en, "R1 enables", {core_en, dummy_en}, 0);
    check(!io_en && !seed_ready, "R1 io/ready", {io_en, seed_ready}, 0);
    check(!win_valid && win_count == 0, "R1 window", win_count, 0);
    rst_n = 1'b1;
    ms = SEED0; wcyc = 0; acc = 0; exp_win = 0; exp_valid = 0; loads = 0;
    zero_done = 0;
    // R1 state held default seed: first decision comes from SEED0
    for (int i = 0; i < CYCLES; i++) begin
      sv = 0;
      if (i == 3) begin
        seed_data = 32'h0001_0001; sv = 1;        // directed: forces pick
      end else if (i == 7) begin
        seed_data = 32'h0; sv = 1; zero_done = 1; // directed R7 zero seed
      end else if (i > 10 && ($urandom % 2000) == 0) begin
        seed_data = $urandom; sv = 1;
      end else begin
        seed_data = $urandom;
      end
      seed_valid = sv;
      @(negedge clk);
      ec = ms[0] & ms[16];
      if (sv) begin ms = ref_seed(seed_data); loads++; end
      else ms = ref_step(ms);
      check(io_en == 1'b1, "R2 io_en", io_en, 1);
      check(seed_ready == 1'b1, "R8 seed_ready", seed_ready, 1);
      check((core_en ^ dummy_en) == 1'b1, "R3 exclusive", {core_en, dummy_en}, 1);
      if (i == 4)
        check(core_en == 1'b1, "R6 loaded seed drives pick", core_en, 1);
      else if (i == 8)
        check(core_en == (SEED0[0] & SEED0[16]), "R7 zero seed", core_en,
              int'(SEED0[0] & SEED0[16]));
      else if (sv)
        check(core_en == ec, "R6 old state on load edge", core_en, ec);
      else
        check(core_en == ec, "R4 R5 core_en", core_en, ec);
      acc += int'(ec);
      wcyc++;
      if (wcyc == WINDOW) begin
        exp_win = acc; exp_valid = 1; wcyc = 0; acc = 0;
        check(win_count == exp_win, "R9 window count", win_count, exp_win);
        check(win_count >= 200 && win_count <= 300, "R10 ratio", win_count, 250);
      end
      check(win_valid == exp_valid, "R9 win_valid", win_valid, exp_valid);
    end
    seed_valid = 1'b0;
    // R1 again: mid-run reset returns everything to idle
    rst_n = 1'b0;
    #1;
    check(!core_en && !dummy_en && !io_en, "R1 reassert", {core_en, dummy_en, io_en}, 0);
    check(!win_valid && win_count == 0, "R1 reassert window", win_count, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(core_en == (SEED0[0] & SEED0[16]), "R1 default seed after reset", core_en,
          int'(SEED0[0] & SEED0[16]));
    check(zero_done && loads > 2, "R6 loads applied", loads, 3);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule